// File: doc/BRIEF.md
# Interrupt Request Detector and Poll Arbiter

This block sits beside the instruction sequencer of an 8-bit processor core and decides, once per instruction, whether the next thing the core runs is a non-maskable interrupt sequence, a maskable interrupt sequence or an ordinary opcode fetch. Two request lines feed it. Each line is active low and is shared by several requesters, so each arrives as a vector of per-source request bits. A set bit means that source is pulling the line down.

The non-maskable line goes through an edge detector. The detector latches a falling edge and holds it until the sequencer acknowledges that the interrupt has been serviced. The maskable line goes through a level detector whose output covers one cycle only. The sequencer strobes the final cycle of every instruction. On that strobe the block samples both detector outputs and registers its decision on two plain control outputs. The non-maskable request always wins, and the I flag masks the maskable request.

There is no data stream here. Every pin is a plain control or status pin, so there is no valid/ready handshake and no back-pressure. A stall of the core is shown by dropping the per-cycle enable.

Top module: `intr_poll_unit`

## Requirements
- R1: A request line counts as low while any bit of its source vector is 1. It counts as high only when every bit is 0. Handing the line from one source to an overlapping second source therefore produces no high period and no new edge.
- R2: A falling edge is seen on an enabled cycle if the NMI line was high at the previous enabled sample and is low now. It sets the internal NMI pending state at that clock edge. A poll on a later enabled edge sees the pending state, but a poll on the same edge does not. A line that stays low raises no further pending state.
- R3: NMI pending stays set until `nmi_ack` is 1 at a clock edge, which clears it. A new falling edge at the same clock edge keeps it set. `nmi_ack` also clears `do_nmi` on any edge that is not a poll.
- R4: The IRQ level detector records the line level at each enabled edge. A poll sees only the level recorded at the previous enabled edge, so an IRQ pulse that ends more than one enabled cycle before the poll is missed.
- R5: A poll is a clock edge with `cyc_en`=1 and `last_cyc`=1. `do_nmi` and `do_irq` change only at a poll, or at an `nmi_ack` as stated in R3.
- R6: At a poll with NMI pending, the result is `do_nmi`=1 and `do_irq`=0, whatever the IRQ level.
- R7: At a poll with `i_flag`=1, `do_irq` becomes 0.
- R8: When `cyc_en`=0, the detectors hold their state. Line changes during the stall are not sampled, and a poll cannot happen.
- R9: Reset sets `do_nmi`=0 and `do_irq`=0 and clears pending state. The previous NMI sample starts as high, so a line that is already low at the first enabled edge counts as an edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_en | input | 1 | Cycle enable; 0 while the core is stalled |
| nmi_req | input | NMI_SRC | Per-source non-maskable requests; 1 pulls the line low |
| irq_req | input | IRQ_SRC | Per-source maskable requests; 1 pulls the line low |
| i_flag | input | 1 | Interrupt-disable flag from the status register |
| last_cyc | input | 1 | Final cycle of the current instruction |
| nmi_ack | input | 1 | Non-maskable interrupt has been serviced |
| do_nmi | output | 1 | Next sequence is the non-maskable interrupt sequence |
| do_irq | output | 1 | Next sequence is the maskable interrupt sequence |

## Verification
A long pseudo-random sweep toggles every source bit, the I flag, the enable, the end-of-instruction strobe and the acknowledge. It compares both outputs every cycle against an arithmetic model of the rules above. This tells apart edge versus level sampling, the one-cycle lifetime of the level sample and the ordering of ack against a new edge. Directed patterns then isolate the remaining cases:
- an NMI edge that arrives mid-instruction and is taken at the next poll;
- an IRQ pulse that ends before the poll and must be missed;
- simultaneous requests, where NMI must win;
- two overlapping sources, which must not re-trigger;
- a masked IRQ;
- a stall that hides an edge.

// File: rtl/intr_pkg.sv
package intr_pkg;

  typedef enum logic [1:0] {
    SEQ_FETCH = 2'd0,
    SEQ_IRQ   = 2'd1,
    SEQ_NMI   = 2'd2
  } seq_kind_e;

  // Priority pick: non-maskable first, maskable only when unmasked.
  function automatic seq_kind_e pick_seq(logic nmi_pend, logic irq_lvl, logic imask);
    if (nmi_pend)              return SEQ_NMI;
    else if (irq_lvl && !imask) return SEQ_IRQ;
    else                       return SEQ_FETCH;
  endfunction

endpackage

// File: rtl/src_merge.sv
module src_merge #(
  parameter int W = 4
) (
  input  logic [W-1:0] src,
  output logic         line_low
);
  generate
    if (W == 1) begin : g_single
      assign line_low = src[0];
    end else begin : g_multi
      assign line_low = |src;
    end
  endgenerate
endmodule

// File: rtl/nmi_edge_det.sv
module nmi_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_en,
  input  logic line_low,
  input  logic ack,
  output logic pend,
  output logic prev_hi
);
  logic fall;
  assign fall = cyc_en && prev_hi && line_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_hi <= 1'b1;
      pend    <= 1'b0;
    end else begin
      if (cyc_en) prev_hi <= !line_low;
      if (fall)       pend <= 1'b1;
      else if (ack)   pend <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_level_det.sv
module irq_level_det (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_en,
  input  logic line_low,
  output logic lvl
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lvl <= 1'b0;
    else if (cyc_en) lvl <= line_low;
  end
endmodule

// File: rtl/intr_poll.sv
module intr_poll
  import intr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_en,
  input  logic last_cyc,
  input  logic i_flag,
  input  logic nmi_ack,
  input  logic nmi_pend,
  input  logic irq_lvl,
  output logic do_nmi,
  output logic do_irq
);
  seq_kind_e pick;
  logic      poll;

  assign poll = cyc_en && last_cyc;
  assign pick = pick_seq(nmi_pend, irq_lvl, i_flag);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      do_nmi <= 1'b0;
      do_irq <= 1'b0;
    end else if (poll) begin
      do_nmi <= (pick == SEQ_NMI);
      do_irq <= (pick == SEQ_IRQ);
    end else if (nmi_ack) begin
      do_nmi <= 1'b0;
    end
  end
endmodule

// File: rtl/intr_poll_unit.sv
module intr_poll_unit #(
  parameter int NMI_SRC = 4,
  parameter int IRQ_SRC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cyc_en,
  input  logic [NMI_SRC-1:0] nmi_req,
  input  logic [IRQ_SRC-1:0] irq_req,
  input  logic               i_flag,
  input  logic               last_cyc,
  input  logic               nmi_ack,
  output logic               do_nmi,
  output logic               do_irq
);
  logic nmi_low, irq_low, nmi_pend, nmi_prev_hi, irq_lvl;

  src_merge #(.W(NMI_SRC)) u_nmi_merge (.src(nmi_req), .line_low(nmi_low));
  src_merge #(.W(IRQ_SRC)) u_irq_merge (.src(irq_req), .line_low(irq_low));

  nmi_edge_det u_nmi_det (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .line_low(nmi_low),
    .ack(nmi_ack), .pend(nmi_pend), .prev_hi(nmi_prev_hi)
  );

  irq_level_det u_irq_det (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .line_low(irq_low), .lvl(irq_lvl)
  );

  intr_poll u_poll (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .last_cyc(last_cyc),
    .i_flag(i_flag), .nmi_ack(nmi_ack), .nmi_pend(nmi_pend), .irq_lvl(irq_lvl),
    .do_nmi(do_nmi), .do_irq(do_irq)
  );
endmodule

// File: rtl/intr_poll_chk.sv
module intr_poll_chk (
  input logic clk,
  input logic rst_n,
  input logic cyc_en,
  input logic last_cyc,
  input logic i_flag,
  input logic nmi_ack,
  input logic nmi_low,
  input logic irq_low,
  input logic nmi_prev_hi,
  input logic nmi_pend,
  input logic irq_lvl,
  input logic do_nmi,
  input logic do_irq
);
  // R6
  nmi_irq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(do_nmi && do_irq));

  // R7
  imask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_en && last_cyc && i_flag) |=> !do_irq);

  // R5
  hold_between_polls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(cyc_en && last_cyc) && !nmi_ack) |=> ($stable(do_nmi) && $stable(do_irq)));

  // R2
  edge_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_en && nmi_prev_hi && nmi_low) |=> nmi_pend);

  // R3
  pend_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_pend && !nmi_ack) |=> nmi_pend);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_en && !nmi_ack) |=> ($stable(nmi_pend) && $stable(irq_lvl) && $stable(nmi_prev_hi)));

  // R4
  level_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_en && !irq_low) |=> !irq_lvl);
endmodule

bind intr_poll_unit intr_poll_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .last_cyc(last_cyc),
  .i_flag(i_flag), .nmi_ack(nmi_ack), .nmi_low(nmi_low), .irq_low(irq_low),
  .nmi_prev_hi(nmi_prev_hi), .nmi_pend(nmi_pend), .irq_lvl(irq_lvl),
  .do_nmi(do_nmi), .do_irq(do_irq)
);

// File: tb/sim_intr_poll_unit.sv
module sim_intr_poll_unit;
  localparam int NS = 4;
  localparam int IS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_en = 1'b0, i_flag = 1'b0, last_cyc = 1'b0, nmi_ack = 1'b0;
  logic [NS-1:0] nmi_req = '0;
  logic [IS-1:0] irq_req = '0;
  logic do_nmi, do_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  bit m_prev_hi, m_pend, m_irq, m_dn, m_di;

  always #4 clk = ~clk;

  intr_poll_unit #(.NMI_SRC(NS), .IRQ_SRC(IS)) u0 (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .nmi_req(nmi_req), .irq_req(irq_req),
    .i_flag(i_flag), .last_cyc(last_cyc), .nmi_ack(nmi_ack),
    .do_nmi(do_nmi), .do_irq(do_irq)
  );

  task automatic check(string tag, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic model_edge();
    bit nl, il, fall, poll;
    nl   = (nmi_req != 0);
    il   = (irq_req != 0);
    fall = cyc_en && m_prev_hi && nl;
    poll = cyc_en && last_cyc;
    if (poll) begin
      m_dn = m_pend;
      m_di = !m_pend && m_irq && !i_flag;
    end else if (nmi_ack) m_dn = 0;
    if (fall) m_pend = 1;
    else if (nmi_ack) m_pend = 0;
    if (cyc_en) begin
      m_prev_hi = !nl;
      m_irq = il;
    end
  endtask

  task automatic cyc(string tag, bit en, bit [NS-1:0] n, bit [IS-1:0] q,
                     bit ifl, bit last, bit ack);
    @(negedge clk);
    cyc_en = en; nmi_req = n; irq_req = q; i_flag = ifl; last_cyc = last; nmi_ack = ack;
    @(posedge clk);
    model_edge();
    #1;
    check(tag, do_nmi, m_dn, "do_nmi");
    check(tag, do_irq, m_di, "do_irq");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    m_prev_hi = 1; m_pend = 0; m_irq = 0; m_dn = 0; m_di = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R9", do_nmi, 1'b0, "reset do_nmi");
    check("R9", do_irq, 1'b0, "reset do_irq");
    @(negedge clk); rst_n = 1'b1;

    // R9: source already asserted at first enabled edge counts as an edge
    cyc("R9", 1, 4'b0010, 0, 0, 0, 0);
    cyc("R9", 1, 4'b0010, 0, 0, 1, 0);
    check("R9", do_nmi, 1'b1, "first-edge poll");
    cyc("R3", 1, 4'b0010, 0, 0, 0, 1);
    check("R3", do_nmi, 1'b0, "ack clears");
    cyc("R2", 1, 0, 0, 0, 1, 0);
    check("R2", do_nmi, 1'b0, "held-low no retrigger");

    // R2: edge mid-instruction, taken at next poll
    cyc("R2", 1, 0, 0, 0, 0, 0);
    cyc("R2", 1, 4'b0001, 0, 0, 0, 0);
    cyc("R2", 1, 0, 0, 0, 0, 0);
    cyc("R2", 1, 0, 0, 0, 1, 0);
    check("R2", do_nmi, 1'b1, "mid-instruction edge");
    cyc("R3", 1, 0, 0, 0, 0, 1);

    // R4: IRQ pulse ending before poll is missed
    cyc("R4", 1, 0, 4'b0100, 0, 0, 0);
    cyc("R4", 1, 0, 0, 0, 0, 0);
    cyc("R4", 1, 0, 0, 0, 1, 0);
    check("R4", do_irq, 1'b0, "missed pulse");
    cyc("R4", 1, 0, 4'b0100, 0, 0, 0);
    cyc("R4", 1, 0, 0, 0, 1, 0);
    check("R4", do_irq, 1'b1, "pulse just before poll");

    // R6: simultaneous
    cyc("R6", 1, 4'b1000, 4'b0001, 0, 0, 0);
    cyc("R6", 1, 4'b1000, 4'b0001, 0, 1, 0);
    check("R6", do_nmi, 1'b1, "nmi wins");
    check("R6", do_irq, 1'b0, "irq dropped");
    cyc("R3", 1, 0, 0, 0, 0, 1);

    // R1: overlapping sources, no high gap, no new edge
    cyc("R1", 1, 4'b0001, 0, 0, 0, 0);
    cyc("R3", 1, 4'b0101, 0, 0, 0, 1);
    cyc("R1", 1, 4'b0100, 0, 0, 0, 0);
    cyc("R1", 1, 4'b0100, 0, 0, 1, 0);
    check("R1", do_nmi, 1'b0, "overlap no retrigger");

    // R7: masked IRQ
    cyc("R7", 1, 0, 4'b0011, 1, 0, 0);
    cyc("R7", 1, 0, 4'b0011, 1, 1, 0);
    check("R7", do_irq, 1'b0, "masked");

    // R8: stall hides an edge, no poll while stalled
    cyc("R8", 1, 0, 0, 0, 0, 0);
    cyc("R8", 0, 4'b0010, 0, 0, 1, 0);
    cyc("R8", 0, 0, 0, 0, 1, 0);
    cyc("R8", 1, 0, 0, 0, 1, 0);
    check("R8", do_nmi, 1'b0, "stalled edge hidden");

    // R5: sweep against model
    begin
      logic [15:0] lf = 16'hACE1;
      for (int i = 0; i < 3000; i++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        cyc("R5", lf[0] | lf[1], lf[5:2] & {4{lf[14]}}, lf[9:6] & {4{lf[15]}},
            lf[10] & lf[11], lf[12], lf[13] & lf[3]);
      end
    end

    finish_run();
  end
endmodule